// File: doc/BRIEF.md
# Dual-Port Address-Match Busy Arbiter

This block sits beside a two-port shared memory and watches the enable and address of each port. When both ports are enabled on the same location, it lets one of them proceed and signals busy (active low) to the other, and it suppresses the write strobe of the port that is held off. Only enable and address take part in the decision. Whether an access reads or writes plays no part in it.

A mode input selects the block's role. In master mode the block makes the decision and drives both busy outputs. In slave mode it makes no decision of its own. The busy outputs stay high, and two externally supplied busy inputs act only as per-port write inhibits. This lets several slaves follow one master when the memory is widened. All inputs are sampled on one clock, and every output is registered, so results appear one cycle after the inputs.

Top module: `dpbusy_arbiter`

## Requirements
- R1: The busy decision depends only on each port's enable and address. The write request inputs never change either busy output.
- R2: A port is settled when it was enabled on the same address in the previous cycle. When a match begins and only one port is settled, that port wins. The other port's busy output goes low one cycle after the inputs that create the match.
- R3: When neither port is settled as a match begins, including both ports becoming valid in the same cycle, the left port wins and right busy goes low. The two busy outputs are never low together.
- R4: One cycle after the addresses differ or either enable is low, both busy outputs are high.
- R5: A write request from a port whose effective busy is active produces no write enable for that port.
- R6: With master mode high, the busy inputs are ignored. With master mode low, both busy outputs are held high, and a low busy input only blocks that port's write enable.
- R7: Busy outputs and busy inputs are active low: 0 means busy.
- R8: The winning port keeps its grant for as long as the match lasts without a break, even when the other port becomes settled or its write request changes.
- R9: Each write enable output equals, one cycle later, enable AND write request AND NOT effective busy for that port. The effective busy is the internal decision in master mode and the busy input in slave mode.
- R10: After synchronous reset (rst_n low at a clock edge), both busy outputs are high and both write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| master_mode | input | 1 | 1 = decide and drive busy, 0 = follow busy inputs |
| lt_en | input | 1 | Left port enable, active high |
| lt_addr | input | ADDR_W | Left port address |
| lt_wr | input | 1 | Left port write request |
| lt_busy_in_n | input | 1 | Left write inhibit in slave mode, active low |
| rt_en | input | 1 | Right port enable, active high |
| rt_addr | input | ADDR_W | Right port address |
| rt_wr | input | 1 | Right port write request |
| rt_busy_in_n | input | 1 | Right write inhibit in slave mode, active low |
| lt_busy_n | output | 1 | Left busy, active low |
| rt_busy_n | output | 1 | Right busy, active low |
| lt_wr_ok | output | 1 | Gated left write enable |
| rt_wr_ok | output | 1 | Gated right write enable |

## Verification
Each result is due one clock after the inputs that cause it, because the busy and write-enable outputs are registered at the same edge that samples the inputs. The settled state of a port is one more register, so a "first" port must have been driven one cycle before its opponent moves onto the matching address. The bench drives every input on the falling edge and samples on the next falling edge, after exactly one rising edge. Every check therefore reads the result of the inputs it has just applied, and the prior cycle sets up the settled history.

// File: rtl/dpbusy_pkg.sv
// Shared types for the dual-port busy arbiter.
package dpbusy_pkg;
    // Which port currently holds the contested location.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_t;

    localparam int NUM_PORTS = 2;
    localparam int PORT_LT   = 0;
    localparam int PORT_RT   = 1;
endpackage

// File: rtl/dpbusy_match.sv
// Address comparator. Reports a collision when both ports are enabled on
// the same address. Assumes enables are active high; purely combinational.
module dpbusy_match #(
    parameter int ADDR_W = 13
) (
    input  logic              lt_en,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              rt_en,
    input  logic [ADDR_W-1:0] rt_addr,
    output logic              match
);
    // Collision when both ports are selected and the addresses agree.
    always_comb begin
        match = lt_en && rt_en && (lt_addr == rt_addr);
    end
endmodule

// File: rtl/dpbusy_arb.sv
// Arbitration state. Remembers each port's enable/address from the previous
// cycle to judge which side was established first, and holds the grant for
// as long as the collision lasts. Assumes the match input is from the
// comparator on the same inputs. Produces the next-cycle busy decision.
module dpbusy_arb
    import dpbusy_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match,
    input  logic              lt_en,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              rt_en,
    input  logic [ADDR_W-1:0] rt_addr,
    output logic [NUM_PORTS-1:0] busy_req
);
    logic              lt_en_q, rt_en_q;
    logic [ADDR_W-1:0] lt_addr_q, rt_addr_q;
    logic              lt_settled, rt_settled;
    owner_t            owner_q, owner_d;

    // Record each port's selection for the settled test.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lt_en_q   <= 1'b0;
            rt_en_q   <= 1'b0;
            lt_addr_q <= '0;
            rt_addr_q <= '0;
        end else begin
            lt_en_q   <= lt_en;
            rt_en_q   <= rt_en;
            lt_addr_q <= lt_addr;
            rt_addr_q <= rt_addr;
        end
    end

    // A port is settled when it kept the same enabled address since last cycle.
    always_comb begin
        lt_settled = lt_en && lt_en_q && (lt_addr == lt_addr_q);
        rt_settled = rt_en && rt_en_q && (rt_addr == rt_addr_q);
    end

    // Pick the owner: hold an existing grant, else earlier port, else left.
    always_comb begin
        if (!match)
            owner_d = OWN_NONE;
        else if (owner_q != OWN_NONE)
            owner_d = owner_q;
        else if (rt_settled && !lt_settled)
            owner_d = OWN_RIGHT;
        else
            owner_d = OWN_LEFT;
    end

    // Store the grant.
    always_ff @(posedge clk) begin
        if (!rst_n)
            owner_q <= OWN_NONE;
        else
            owner_q <= owner_d;
    end

    // The losing side is the busy one.
    always_comb begin
        busy_req[PORT_LT] = (owner_d == OWN_RIGHT);
        busy_req[PORT_RT] = (owner_d == OWN_LEFT);
    end

    // R8: a grant survives while the collision continues.
    assert_grant_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == OWN_LEFT && match) |=> (owner_q == OWN_LEFT));
    assert_grant_held_rt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == OWN_RIGHT && match) |=> (owner_q == OWN_RIGHT));
endmodule

// File: rtl/dpbusy_gate.sv
// Per-port output stage. Selects the effective busy (internal decision in
// master mode, external inhibit in slave mode), registers the active-low busy
// output and the gated write enable. Assumes busy_in_n is active low.
module dpbusy_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic master_mode,
    input  logic busy_req,
    input  logic busy_in_n,
    input  logic en,
    input  logic wr,
    output logic busy_n,
    output logic wr_ok
);
    logic busy_eff;

    // Effective busy depends on the role.
    always_comb begin
        busy_eff = master_mode ? busy_req : !busy_in_n;
    end

    // Register the busy pin and the gated write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_n <= 1'b1;
            wr_ok  <= 1'b0;
        end else begin
            busy_n <= !(master_mode && busy_req);
            wr_ok  <= en && wr && !busy_eff;
        end
    end

    // R5: a port shown busy never gets a write.
    assert_no_write_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ok && !busy_n));
    // R6: in slave mode an active inhibit input blocks the write.
    assert_slave_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(master_mode) && !$past(busy_in_n)) |-> !wr_ok);
    // R6: slaves never drive busy low.
    assert_slave_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(master_mode) |-> busy_n);
endmodule

// File: rtl/dpbusy_arbiter.sv
// Top of the dual-port busy arbiter. Wires the comparator, the arbitration
// state and one output stage per port. Assumes all inputs are synchronous
// to clk; all outputs are registered, one cycle after their inputs.
module dpbusy_arbiter
    import dpbusy_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              lt_en,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              lt_wr,
    input  logic              lt_busy_in_n,
    input  logic              rt_en,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_wr,
    input  logic              rt_busy_in_n,
    output logic              lt_busy_n,
    output logic              rt_busy_n,
    output logic              lt_wr_ok,
    output logic              rt_wr_ok
);
    logic                 match;
    logic [NUM_PORTS-1:0] busy_req;
    logic [NUM_PORTS-1:0] en_v, wr_v, bin_v, bout_v, ok_v;

    // Gather per-port signals into vectors for the generated stages.
    always_comb begin
        en_v  = {rt_en, lt_en};
        wr_v  = {rt_wr, lt_wr};
        bin_v = {rt_busy_in_n, lt_busy_in_n};
    end

    dpbusy_match #(.ADDR_W(ADDR_W)) u_match (
        .lt_en(lt_en), .lt_addr(lt_addr),
        .rt_en(rt_en), .rt_addr(rt_addr),
        .match(match)
    );

    dpbusy_arb #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .match(match),
        .lt_en(lt_en), .lt_addr(lt_addr),
        .rt_en(rt_en), .rt_addr(rt_addr),
        .busy_req(busy_req)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpbusy_gate u_gate (
            .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
            .busy_req(busy_req[p]), .busy_in_n(bin_v[p]),
            .en(en_v[p]), .wr(wr_v[p]),
            .busy_n(bout_v[p]), .wr_ok(ok_v[p])
        );
    end

    // Present the per-port results on the named ports.
    always_comb begin
        lt_busy_n = bout_v[PORT_LT];
        rt_busy_n = bout_v[PORT_RT];
        lt_wr_ok  = ok_v[PORT_LT];
        rt_wr_ok  = ok_v[PORT_RT];
    end

    // R3: both sides are never told busy together.
    assert_single_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lt_busy_n && !rt_busy_n));
    // R4: busy is only shown after a collision was present.
    assert_busy_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lt_busy_n || !rt_busy_n) |-> $past(match));
endmodule

// File: tb/dpbusy_arbiter_test.sv
// Directed bench for the dual-port busy arbiter.
module dpbusy_arbiter_test;
    localparam int ADDR_W = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              master_mode = 1'b1;
    logic              lt_en = 1'b0, rt_en = 1'b0;
    logic [ADDR_W-1:0] lt_addr = '0, rt_addr = '0;
    logic              lt_wr = 1'b0, rt_wr = 1'b0;
    logic              lt_busy_in_n = 1'b1, rt_busy_in_n = 1'b1;
    logic              lt_busy_n, rt_busy_n, lt_wr_ok, rt_wr_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dpbusy_arbiter #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .lt_en(lt_en), .lt_addr(lt_addr), .lt_wr(lt_wr), .lt_busy_in_n(lt_busy_in_n),
        .rt_en(rt_en), .rt_addr(rt_addr), .rt_wr(rt_wr), .rt_busy_in_n(rt_busy_in_n),
        .lt_busy_n(lt_busy_n), .rt_busy_n(rt_busy_n),
        .lt_wr_ok(lt_wr_ok), .rt_wr_ok(rt_wr_ok)
    );

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    // Apply one cycle of inputs at the falling edge; results are read at the next one.
    task automatic step(input logic le, input int la, input logic lw,
                        input logic re, input int ra, input logic rw);
        lt_en = le; lt_addr = ADDR_W'(la); lt_wr = lw;
        rt_en = re; rt_addr = ADDR_W'(ra); rt_wr = rw;
        @(negedge clk);
    endtask

    task automatic expect4(input string req, input logic lb, input logic rb,
                           input logic lo, input logic ro);
        chk(req, "lt_busy_n", lt_busy_n, lb);
        chk(req, "rt_busy_n", rt_busy_n, rb);
        chk(req, "lt_wr_ok",  lt_wr_ok,  lo);
        chk(req, "rt_wr_ok",  rt_wr_ok,  ro);
    endtask

    task automatic t_reset;
        step(1, 4, 1, 1, 4, 1);
        expect4("R10", 1, 1, 0, 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_left_first;
        step(1, 5, 0, 1, 9, 0);              // left settles on 5
        step(1, 5, 1, 1, 5, 1);              // right moves onto 5
        expect4("R2", 1, 0, 1, 0);           // R5/R9: right write blocked
        step(1, 5, 0, 1, 5, 1);              // right now settled too; R8 hold, R1 wr irrelevant
        expect4("R8", 1, 0, 0, 0);
        step(1, 5, 1, 1, 5, 0);
        expect4("R1", 1, 0, 1, 0);
        step(1, 5, 1, 1, 6, 1);              // addresses differ
        expect4("R4", 1, 1, 1, 1);
        step(0, 6, 1, 1, 6, 1);              // left disabled on same address
        expect4("R4", 1, 1, 0, 1);
    endtask

    task automatic t_right_first;
        step(0, 0, 0, 1, 7, 0);              // right settles on 7
        step(1, 7, 1, 1, 7, 1);
        expect4("R2", 0, 1, 0, 1);           // left loses, R5 left write blocked
        step(1, 7, 0, 1, 7, 0);
        expect4("R7", 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        expect4("R4", 1, 1, 0, 0);
    endtask

    task automatic t_tie;
        step(1, 3, 1, 1, 3, 1);              // both valid in the same cycle
        expect4("R3", 1, 0, 1, 0);
        step(1, 3, 0, 1, 3, 0);
        expect4("R3", 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_slave;
        master_mode = 1'b0;
        lt_busy_in_n = 1'b0;
        step(1, 2, 1, 1, 2, 1);              // collision, but slaves do not decide
        expect4("R6", 1, 1, 0, 1);
        lt_busy_in_n = 1'b1; rt_busy_in_n = 1'b0;
        step(1, 2, 1, 1, 2, 1);
        expect4("R6", 1, 1, 1, 0);
        rt_busy_in_n = 1'b1;
        step(1, 2, 1, 1, 2, 1);
        expect4("R9", 1, 1, 1, 1);
    endtask

    task automatic t_master_ignores_inputs;
        master_mode = 1'b1;
        step(0, 0, 0, 0, 0, 0);
        lt_busy_in_n = 1'b0; rt_busy_in_n = 1'b0;
        step(1, 10, 1, 1, 11, 1);
        expect4("R6", 1, 1, 1, 1);
        lt_busy_in_n = 1'b1; rt_busy_in_n = 1'b1;
        step(0, 10, 1, 1, 11, 0);            // R9: enable required for a write
        expect4("R9", 1, 1, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_left_first();
        t_right_first();
        t_tie();
        t_slave();
        t_master_ignores_inputs();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule